// File: doc/BRIEF.md
# Fault Collector with Threshold Escalation

This block gathers single-cycle fault pulses from a parameterised set of input records and condenses them into two registered lines for the next level of a fault hierarchy: one for critical faults and one for non-critical faults. Each record may come from a local safety mechanism, or from one of the two output lines of a lower-level collector. In a tree, a child's critical line and its non-critical line go to two different record indices of the parent.

Each record has its own set of state. It has a valid flag and a saturating occurrence counter. It also has a configuration word that holds an enable bit, a static class bit, an upgrade bit and a threshold. When upgrade is on and the count rises above the threshold, the record counts as critical even if its static class is non-critical. Software reaches the block through a plain write/read register port. Configuration, count overwrite and fault injection are protected: each needs a key write first, and the key allows only one protected write. Valid flags appear in grouped status words of `DW` bits, and software clears them by writing ones back to those words.

Top module: `fault_hub`

## Requirements
- R1: `crit_out` is the registered OR of the records that are valid, enabled and classed critical. `ncrit_out` is the registered OR of the records that are valid, enabled and not classed critical. Each line changes one cycle after the valid flag that drives it changes.
- R2: A record whose config bit 0 (enable) is 0 ignores both its input and injection: its count and valid flag do not change. While it is disabled, it also drives neither output.
- R3: Each record's count increments on every accepted fault and saturates at 2^CNT_W-1. It reads at address 0x80+i, and a protected write to that address overwrites it.
- R4: A record is critical when config bit 1 (static class) is 1, or when config bit 2 (upgrade) is 1 and its count is strictly greater than config bits [8+:CNT_W] (threshold). Config reads back at 0x40+i.
- R5: A protected write of index i to address 0x01 injects a fault into record i that behaves like a one-cycle input pulse.
- R6: Writing KEY_VAL to address 0x00 allows exactly one protected write (addresses 0x01, 0x40-0x7F, 0x80-0xBF), after which the block relocks. Writing any other value to 0x00 relocks it.
- R7: A protected write made while locked has no effect and sets a sticky error flag, readable at bit 0 of address 0x04.
- R8: Status word g at address 0x08+g holds the valid flags of records g*DW to g*DW+DW-1. Writing a 1 to a bit clears that flag. A fault arriving on the same cycle wins over the clear.
- R9: `new_fault` pulses for one cycle after a record changes from not valid to valid. A repeated fault on a record that is already valid increments its count but raises no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_in | input | NREC | One-cycle fault pulses, one per record |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| crit_out | output | 1 | Registered critical fault line |
| ncrit_out | output | 1 | Registered non-critical fault line |
| new_fault | output | 1 | One-cycle pulse when any record newly becomes valid |

## Verification
The main aggregation path is driven with a table of fault patterns. The table covers a single non-critical record, a single static-critical record, and the same upgrade record below and then above its threshold. It also covers a pulse on a disabled record, two non-critical records together, and a mix of critical, non-critical and disabled records. Each pattern therefore shows a separate case: class by static bit, class by escalation, masking by enable, or both lines raised together. Directed sequences then cover saturation, repeated faults, a clear and a fault on the same cycle, injection, a single-use key, a wrong key, and disabling a record while it is valid.

// File: rtl/fault_hub_pkg.sv
package fault_hub_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_KEY,
    RG_INJ,
    RG_ERR,
    RG_STAT,
    RG_CFG,
    RG_CNT
  } region_e;

  function automatic region_e decode_addr(input logic [7:0] a);
    if (a == 8'h00)             return RG_KEY;
    else if (a == 8'h01)        return RG_INJ;
    else if (a == 8'h04)        return RG_ERR;
    else if (a[7:3] == 5'b00001) return RG_STAT;
    else if (a[7:6] == 2'b01)   return RG_CFG;
    else if (a[7:6] == 2'b10)   return RG_CNT;
    else                        return RG_NONE;
  endfunction

  // saturating increment on a 16-bit carrier
  function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] vmax);
    return (v >= vmax) ? vmax : v + 16'd1;
  endfunction

  // escalation to critical when count passes threshold
  function automatic logic escalates(input logic [15:0] c, input logic [15:0] t, input logic up);
    return up && (c > t);
  endfunction

endpackage

// File: rtl/fh_key_guard.sv
module fh_key_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  logic key_match,
  input  logic prot_wr,
  output logic prot_ok,
  output logic key_err
);

  logic unlocked;

  assign prot_ok = prot_wr && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      key_err  <= 1'b0;
    end else begin
      if (prot_wr)     unlocked <= 1'b0;
      else if (key_wr) unlocked <= key_match;
      if (prot_wr && !unlocked) key_err <= 1'b1;
    end
  end

  // R6
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr |=> !unlocked);

  // R7
  denied_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && !unlocked) |=> key_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |=> key_err);

endmodule

// File: rtl/fh_record.sv
module fh_record #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt,
  input  logic             inj,
  input  logic             ack,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic             cfg_crit,
  input  logic             cfg_upg,
  input  logic [CNT_W-1:0] cfg_thr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             en,
  output logic             valid,
  output logic             is_crit,
  output logic             newly,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] thr,
  output logic             crit_st,
  output logic             upg
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic        hit;
  logic [15:0] inc16;

  assign hit     = en && (flt || inj);
  assign newly   = hit && !valid;
  assign inc16   = fault_hub_pkg::sat_inc(16'(cnt), 16'(CMAX));
  assign is_crit = crit_st || fault_hub_pkg::escalates(16'(cnt), 16'(thr), upg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      crit_st <= 1'b0;
      upg     <= 1'b0;
      thr     <= CMAX;
      cnt     <= '0;
      valid   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        en      <= cfg_en;
        crit_st <= cfg_crit;
        upg     <= cfg_upg;
        thr     <= cfg_thr;
      end
      if (cnt_wr)   cnt <= cnt_wdata;
      else if (hit) cnt <= inc16[CNT_W-1:0];
      if (hit)      valid <= 1'b1;
      else if (ack) valid <= 1'b0;
    end
  end

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && hit && !cnt_wr) |=> cnt == CMAX);

  // R2
  dis_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt));

  // R2
  dis_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !valid) |=> !valid);

  // R9
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && valid) |=> valid);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !valid);

endmodule

// File: rtl/fh_out.sv
module fh_out #(
  parameter int NREC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREC-1:0] valid,
  input  logic [NREC-1:0] en,
  input  logic [NREC-1:0] is_crit,
  input  logic [NREC-1:0] newly,
  output logic            crit_out,
  output logic            ncrit_out,
  output logic            new_fault
);

  logic [NREC-1:0] live;
  assign live = valid & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_out  <= 1'b0;
      ncrit_out <= 1'b0;
      new_fault <= 1'b0;
    end else begin
      crit_out  <= |(live & is_crit);
      ncrit_out <= |(live & ~is_crit);
      new_fault <= |newly;
    end
  end

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == '0) |=> (!crit_out && !ncrit_out));

  // R9
  evt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_fault |-> (valid != '0));

endmodule

// File: rtl/fault_hub.sv
module fault_hub #(
  parameter int          NREC    = 8,
  parameter int          CNT_W   = 4,
  parameter int          DW      = 16,
  parameter logic [15:0] KEY_VAL = 16'hBE5A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREC-1:0] flt_in,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            crit_out,
  output logic            ncrit_out,
  output logic            new_fault
);
  import fault_hub_pkg::*;

  localparam int GROUPS = (NREC + DW - 1) / DW;
  localparam int PADW   = GROUPS * DW;

  region_e         rg;
  logic            prot_wr, key_wr, prot_ok, key_err;
  logic [5:0]      idx;
  logic [NREC-1:0] inj_vec, ack_vec, cfg_wr, cnt_wr;
  logic [NREC-1:0] en_v, valid_v, crit_v, newly_v, crit_st_v, upg_v;
  logic [CNT_W-1:0] cnt_v [NREC];
  logic [CNT_W-1:0] thr_v [NREC];
  logic [PADW-1:0] stat_pad;

  assign rg      = decode_addr(reg_addr);
  assign idx     = reg_addr[5:0];
  assign key_wr  = reg_wr && (rg == RG_KEY);
  assign prot_wr = reg_wr && (rg == RG_INJ || rg == RG_CFG || rg == RG_CNT);
  assign stat_pad = PADW'(valid_v);

  fh_key_guard guard_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .key_match (16'(reg_wdata) == KEY_VAL),
    .prot_wr   (prot_wr),
    .prot_ok   (prot_ok),
    .key_err   (key_err)
  );

  for (genvar i = 0; i < NREC; i++) begin : g_rec
    localparam int GRP = i / DW;
    localparam int BIT = i % DW;

    assign inj_vec[i] = prot_ok && (rg == RG_INJ) && (int'(reg_wdata) == i);
    assign cfg_wr[i]  = prot_ok && (rg == RG_CFG) && (int'(idx) == i);
    assign cnt_wr[i]  = prot_ok && (rg == RG_CNT) && (int'(idx) == i);
    assign ack_vec[i] = reg_wr && (rg == RG_STAT) && (int'(reg_addr[2:0]) == GRP)
                        && reg_wdata[BIT];

    fh_record #(.CNT_W(CNT_W)) rec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flt       (flt_in[i]),
      .inj       (inj_vec[i]),
      .ack       (ack_vec[i]),
      .cfg_wr    (cfg_wr[i]),
      .cfg_en    (reg_wdata[0]),
      .cfg_crit  (reg_wdata[1]),
      .cfg_upg   (reg_wdata[2]),
      .cfg_thr   (reg_wdata[8 +: CNT_W]),
      .cnt_wr    (cnt_wr[i]),
      .cnt_wdata (reg_wdata[CNT_W-1:0]),
      .en        (en_v[i]),
      .valid     (valid_v[i]),
      .is_crit   (crit_v[i]),
      .newly     (newly_v[i]),
      .cnt       (cnt_v[i]),
      .thr       (thr_v[i]),
      .crit_st   (crit_st_v[i]),
      .upg       (upg_v[i])
    );
  end

  fh_out #(.NREC(NREC)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid_v),
    .en        (en_v),
    .is_crit   (crit_v),
    .newly     (newly_v),
    .crit_out  (crit_out),
    .ncrit_out (ncrit_out),
    .new_fault (new_fault)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (rg)
      RG_ERR:  reg_rdata = DW'(key_err);
      RG_STAT: begin
        for (int g = 0; g < GROUPS; g++)
          if (int'(reg_addr[2:0]) == g) reg_rdata = stat_pad[g*DW +: DW];
      end
      RG_CFG: begin
        for (int i = 0; i < NREC; i++)
          if (int'(idx) == i)
            reg_rdata = DW'({thr_v[i], 5'b0, upg_v[i], crit_st_v[i], en_v[i]});
      end
      RG_CNT: begin
        for (int i = 0; i < NREC; i++)
          if (int'(idx) == i) reg_rdata = DW'(cnt_v[i]);
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/fault_hub_tb_top.sv
module fault_hub_tb_top;

  localparam int          NREC = 8;
  localparam logic [15:0] KEY  = 16'hBE5A;
  localparam int          NV   = 9;
  // fault pattern per vector and expected {crit, ncrit}
  localparam logic [7:0] PAT [NV] = '{8'h01, 8'h02, 8'h04, 8'h04, 8'h10,
                                      8'h09, 8'h06, 8'h13, 8'h00};
  localparam logic [1:0] EXP [NV] = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b00,
                                      2'b01, 2'b10, 2'b11, 2'b00};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREC-1:0] flt_in = '0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic [15:0]     reg_wdata = '0;
  logic [15:0]     reg_rdata;
  logic            crit_out, ncrit_out, new_fault;
  int              total = 0, fails = 0;
  logic            done = 1'b0;

  always #10 clk = ~clk;

  fault_hub #(.NREC(NREC), .CNT_W(4), .DW(16), .KEY_VAL(KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .flt_in(flt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .crit_out(crit_out), .ncrit_out(ncrit_out), .new_fault(new_fault));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pwr(input logic [7:0] a, input logic [15:0] d);
    wr(8'h00, KEY);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); flt_in = m;
    @(negedge clk); flt_in = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset crit", 16'(crit_out), 16'h0);
    chk("R1 reset ncrit", 16'(ncrit_out), 16'h0);
    chk("R9 reset evt", 16'(new_fault), 16'h0);
    rd(8'h08, d); chk("R8 reset status", d, 16'h0);
    rd(8'h04, d); chk("R7 reset err", d, 16'h0);
    rd(8'h40, d); chk("R4 reset cfg", d, 16'h0F00);
    rd(8'h80, d); chk("R3 reset count", d, 16'h0);

    // configuration: r0 nc, r1 static crit, r2 upgrade thr 1, r3 nc, r4 disabled crit
    pwr(8'h40, 16'h0F01);
    pwr(8'h41, 16'h0F03);
    pwr(8'h42, 16'h0105);
    pwr(8'h43, 16'h0F01);
    pwr(8'h44, 16'h0F02);
    rd(8'h42, d); chk("R4 cfg readback", d, 16'h0105);

    // table walk (R1, R2, R4)
    for (int v = 0; v < NV; v++) begin
      pulse(PAT[v]);
      chk($sformatf("R9 evt v%0d", v), 16'(new_fault), 16'(|(PAT[v] & 8'h0F)));
      rd(8'h08, d); chk($sformatf("R8 status v%0d", v), d, 16'(PAT[v] & 8'h0F));
      @(negedge clk);
      chk($sformatf("R1 R4 lines v%0d", v), 16'({crit_out, ncrit_out}), 16'(EXP[v]));
      wr(8'h08, 16'h00FF);
      @(negedge clk);
      chk($sformatf("R1 cleared v%0d", v), 16'({crit_out, ncrit_out}), 16'h0);
    end
    rd(8'h82, d); chk("R3 upgrade record count", d, 16'd3);

    // R3 overwrite and saturation, R9 repeated fault
    pwr(8'h83, 16'd14);
    rd(8'h83, d); chk("R3 overwrite", d, 16'd14);
    pulse(8'h08);
    chk("R9 first evt", 16'(new_fault), 16'h1);
    pulse(8'h08);
    chk("R9 repeat no evt", 16'(new_fault), 16'h0);
    rd(8'h83, d); chk("R3 saturate", d, 16'd15);
    pulse(8'h08);
    rd(8'h83, d); chk("R3 hold at max", d, 16'd15);
    chk("R1 nc line", 16'({crit_out, ncrit_out}), 16'h1);

    // R8 fault wins over clear on same cycle
    @(negedge clk); flt_in = 8'h08; reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 16'h0008;
    @(negedge clk); flt_in = '0; reg_wr = 1'b0;
    rd(8'h08, d); chk("R8 fault beats clear", d, 16'h0008);
    wr(8'h08, 16'h0008);
    rd(8'h08, d); chk("R8 clear", d, 16'h0);
    chk("R1 line one cycle late", 16'(ncrit_out), 16'h1);
    @(negedge clk);
    chk("R1 line dropped", 16'(ncrit_out), 16'h0);

    // R5 injection
    pwr(8'h01, 16'd0);
    chk("R5 inject evt", 16'(new_fault), 16'h1);
    rd(8'h08, d); chk("R5 inject status", d, 16'h0001);
    @(negedge clk);
    chk("R5 inject line", 16'(ncrit_out), 16'h1);
    pwr(8'h01, 16'd4);
    rd(8'h08, d); chk("R2 inject disabled ignored", d, 16'h0001);
    rd(8'h84, d); chk("R2 disabled count", d, 16'h0);
    wr(8'h08, 16'h00FF);

    // R6 single-use key, R7 locked write
    pwr(8'h45, 16'h0F01);
    rd(8'h45, d); chk("R6 unlocked write", d, 16'h0F01);
    wr(8'h46, 16'h0F01);
    rd(8'h46, d); chk("R6 relocked ignore", d, 16'h0F00);
    rd(8'h04, d); chk("R7 sticky err", d, 16'h1);
    wr(8'h00, 16'h1234);
    wr(8'h47, 16'h0F01);
    rd(8'h47, d); chk("R6 wrong key ignore", d, 16'h0F00);
    wr(8'h01, 16'd5);
    rd(8'h08, d); chk("R7 locked inject ignored", d, 16'h0);

    // R2 disabling a valid record
    pulse(8'h02);
    @(negedge clk);
    chk("R2 crit before disable", 16'(crit_out), 16'h1);
    pwr(8'h41, 16'h0F02);
    @(negedge clk);
    chk("R2 disabled masks line", 16'(crit_out), 16'h0);
    rd(8'h08, d); chk("R2 valid kept", d, 16'h0002);
    rd(8'h81, d); chk("R2 count before", d, 16'd4);
    pulse(8'h02);
    rd(8'h81, d); chk("R2 disabled count stable", d, 16'd4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule